// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block is the host-side engine that loads a three-wire serial digital-to-analog converter. A client hands it a 12-bit output code and a 2-bit operating mode over a valid/ready request. The engine packs them into a 16-bit word and sends it most significant bit first. It frames the word with an active-low select line and produces exactly sixteen serial clock periods. Data changes only on rising clock edges, so it is stable at every falling edge, where the converter captures it.

The serial clock is made by dividing the system clock. The length of each clock phase and the length of the select-high gap are set in system clock cycles on two configuration inputs. These inputs are sampled when a request is accepted. Before a frame, the engine raises select for the gap time so that the frame opens on a clean falling edge of select. After the last falling clock edge, it raises select again for the gap time. While idle, it parks select, clock and data low to save power at the converter.

Top module: `dac_frame_writer`

## Requirements
- R1: Each frame carries 16 bits, most significant first: bits 15..14 are zero, bits 13..12 are the request mode, and bits 11..0 are the request code.
- R2: While select is low, the data line changes only in the same cycle as a rising serial clock edge. It never changes while the clock is high, so it is stable at every falling edge.
- R3: Each frame has exactly 16 falling clock edges while select is low. Select never rises before the 16th falling edge, and the clock is high only while select is low.
- R4: Every high phase and every low phase of the serial clock lasts H system cycles, where H is the phase-length input sampled at acceptance. A value of 0 is treated as 1. The low phase after select falls and before the first rising edge also lasts H cycles, and so does the low phase after the 16th falling edge.
- R5: Select is high for exactly G cycles before it falls at frame start, and again for exactly G cycles after the frame. G is the gap input sampled at acceptance, with 0 treated as 1.
- R6: From reset and whenever idle, ready is high and select, clock and data are all low.
- R7: A request is taken only in a cycle with valid and ready both high. Ready is low from the next cycle for exactly 2G+33H cycles and is then high again.
- R8: Changing the phase-length or gap inputs while a frame is in progress has no effect on that frame's timing.
- R9: A valid pulse that starts and ends while ready is low is ignored: no further frame follows, and the lines stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request valid |
| req_code_i | input | 12 | Output code to send |
| req_mode_i | input | 2 | Operating mode to send |
| req_ready_o | output | 1 | Engine can accept a request |
| half_cycles_i | input | 8 | Serial clock phase length in system cycles |
| gap_cycles_i | input | 8 | Select-high gap length in system cycles |
| sclk_o | output | 1 | Serial clock, idles low |
| sel_n_o | output | 1 | Active-low frame select |
| sdo_o | output | 1 | Serial data, idles low |

## Verification
All outputs are registered. Select therefore rises in the cycle after the accepting edge, falls G cycles later, and the first rising clock edge comes H cycles after that. Ready returns 2G+33H cycles after acceptance. The bench drives inputs and samples outputs on falling system clock edges. It decodes each frame with a run-length monitor that counts every select and clock phase in whole cycles and compares each count with the value derived from the sampled H and G. It also collects the data bit present just before each clock fall, and then checks the idle state at the exact sample where ready returns.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_LEAD,
    ST_HI,
    ST_LO,
    ST_TAIL
  } wr_state_t;
endpackage

// File: rtl/dac_wr_timer.sv
module dac_wr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= (len_i == '0) ? '0 : len_i - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/dac_wr_shift.sv
module dac_wr_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         head_o,
  output logic         next_o
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (load_i) begin
      sr <= word_i;
    end else if (shift_i) begin
      sr <= {sr[W-2:0], 1'b0};
    end
  end

  assign head_o = sr[W-1];
  assign next_o = sr[W-2];
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
  import dac_wr_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2,
  parameter int PAD_W  = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic [MODE_W-1:0] req_mode_i,
  output logic              req_ready_o,
  input  logic [CNT_W-1:0]  half_cycles_i,
  input  logic [CNT_W-1:0]  gap_cycles_i,
  output logic              sclk_o,
  output logic              sel_n_o,
  output logic              sdo_o
);
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam logic [BIT_W-1:0] LAST_FALL = BIT_W'(FRAME_W);

  wr_state_t        state;
  logic [CNT_W-1:0] h_q, g_q;
  logic [BIT_W-1:0] fall_cnt;

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_len;
  logic             sh_load, sh_shift, sh_head, sh_next;
  logic             accept;

  assign accept = req_valid_i && req_ready_o;

  dac_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  dac_wr_shift #(.W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (sh_load),
    .word_i  ({{PAD_W{1'b0}}, req_mode_i, req_code_i}),
    .shift_i (sh_shift),
    .head_o  (sh_head),
    .next_o  (sh_next)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = h_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_len  = gap_cycles_i;
        sh_load  = 1'b1;
      end
      ST_ARM, ST_LEAD, ST_HI: tmr_load = tmr_done;
      ST_LO: if (tmr_done) begin
        tmr_load = 1'b1;
        if (fall_cnt == LAST_FALL) tmr_len = g_q;
        else sh_shift = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready_o <= 1'b1;
      sel_n_o     <= 1'b0;
      sclk_o      <= 1'b0;
      sdo_o       <= 1'b0;
      fall_cnt    <= '0;
      h_q         <= '0;
      g_q         <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          req_ready_o <= 1'b0;
          sel_n_o     <= 1'b1;
          h_q         <= half_cycles_i;
          g_q         <= gap_cycles_i;
          fall_cnt    <= '0;
          state       <= ST_ARM;
        end
        ST_ARM: if (tmr_done) begin
          sel_n_o <= 1'b0;
          sdo_o   <= sh_head;
          state   <= ST_LEAD;
        end
        ST_LEAD: if (tmr_done) begin
          sclk_o <= 1'b1;
          state  <= ST_HI;
        end
        ST_HI: if (tmr_done) begin
          sclk_o   <= 1'b0;
          fall_cnt <= fall_cnt + 1'b1;
          state    <= ST_LO;
        end
        ST_LO: if (tmr_done) begin
          if (fall_cnt == LAST_FALL) begin
            sel_n_o <= 1'b1;
            sdo_o   <= 1'b0;
            state   <= ST_TAIL;
          end else begin
            sclk_o <= 1'b1;
            sdo_o  <= sh_next;
            state  <= ST_HI;
          end
        end
        ST_TAIL: if (tmr_done) begin
          sel_n_o     <= 1'b0;
          req_ready_o <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: data held steady across a high clock phase
  a_r2_sdo_steady_high: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  // R3: clock toggles only inside a frame
  a_r3_sclk_inside_frame: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> !sel_n_o);

  // R3: closing select rise only after all falling edges
  a_r3_no_early_close: assert property (@(posedge clk) disable iff (rst)
    ($rose(sel_n_o) && !$past(req_ready_o)) |-> (fall_cnt == LAST_FALL));

  // R6: idle line levels
  a_r6_idle_lines: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> (!sel_n_o && !sclk_o && !sdo_o));

  // R7: ready drops after a taken request
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: tb/dac_frame_writer_test.sv
`timescale 1ns/1ps
module dac_frame_writer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_code = '0;
  logic [1:0]  req_mode = '0;
  logic [7:0]  half_cycles = 8'd4;
  logic [7:0]  gap_cycles = 8'd5;
  logic        req_ready, sclk, sel_n, sdo;

  int n_checks = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dac_frame_writer uut (
    .clk           (clk),
    .rst           (rst),
    .req_valid_i   (req_valid),
    .req_code_i    (req_code),
    .req_mode_i    (req_mode),
    .req_ready_o   (req_ready),
    .half_cycles_i (half_cycles),
    .gap_cycles_i  (gap_cycles),
    .sclk_o        (sclk),
    .sel_n_o       (sel_n),
    .sdo_o         (sdo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // Sends one frame and decodes the lines; poke_cfg and poke_req
  // disturb the inputs while the frame is in flight (R8, R9).
  task automatic send(input logic [11:0] code, input logic [1:0] mode,
                      input int h, input int g, input bit poke_cfg, input bit poke_req);
    int eh, eg, arm, lead, tail, busy, falls, bad_hi, bad_lo, bad_sdo, last_lo, run, ph;
    logic [15:0] got, expw;
    logic psclk, psel, psdo;
    eh = (h == 0) ? 1 : h;
    eg = (g == 0) ? 1 : g;
    expw = {2'b00, mode, code};
    arm = 0; lead = 0; tail = 0; busy = 0; falls = 0;
    bad_hi = 0; bad_lo = 0; bad_sdo = 0; last_lo = 0; run = 0; ph = 0; got = '0;
    @(negedge clk);
    check(req_ready === 1'b1, "R7 ready before request", int'(req_ready), 1);
    half_cycles = 8'(h);
    gap_cycles  = 8'(g);
    req_code = code;
    req_mode = mode;
    req_valid = 1'b1;
    psclk = sclk; psel = sel_n; psdo = sdo;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (req_ready === 1'b1 || busy > 5000) break;
      busy++;
      if (poke_cfg && busy == 1) begin
        half_cycles = 8'd1;
        gap_cycles  = 8'd1;
      end
      if (poke_req && busy == 10) begin
        req_code = 12'h555;
        req_valid = 1'b1;
      end
      if (poke_req && busy == 11) req_valid = 1'b0;
      if (sdo !== psdo && !(sclk && !psclk) && (sel_n === psel)) bad_sdo++;
      case (ph)
        0: if (sel_n) arm++; else begin ph = 1; lead = 1; end
        1: if (sclk) begin ph = 2; run = 1; end else lead++;
        2: if (sel_n) begin ph = 3; tail = 1; last_lo = run; end
           else if (sclk !== psclk) begin
             if (psclk) begin
               falls++;
               got = {got[14:0], psdo};
               if (run != eh) bad_hi++;
             end else if (run != eh) bad_lo++;
             run = 1;
           end else run++;
        default: if (sel_n) tail++;
      endcase
      psclk = sclk; psel = sel_n; psdo = sdo;
      @(negedge clk);
    end
    half_cycles = 8'(h);
    gap_cycles  = 8'(g);
    check(got === expw, "R1 frame word", int'(got), int'(expw));
    check(falls == 16, "R3 falling edge count", falls, 16);
    check(bad_sdo == 0, "R2 data moved off rising edge", bad_sdo, 0);
    check(bad_hi == 0 && bad_lo == 0, "R4 phase lengths", bad_hi + bad_lo, 0);
    check(lead == eh, "R4 lead low phase", lead, eh);
    check(last_lo == eh, "R4 final low phase", last_lo, eh);
    check(arm == eg, "R5 opening gap", arm, eg);
    check(tail == eg, "R5 closing gap", tail, eg);
    check(busy == 2 * eg + 33 * eh, "R7 busy length", busy, 2 * eg + 33 * eh);
    check(!sel_n && !sclk && !sdo, "R6 idle after frame", {sel_n, sclk, sdo}, 0);
  endtask

  task automatic t_reset();
    check(req_ready === 1'b1, "R6 reset ready", int'(req_ready), 1);
    check({sel_n, sclk, sdo} === 3'b000, "R6 reset lines", int'({sel_n, sclk, sdo}), 0);
  endtask

  task automatic t_basic();
    send(12'hABC, 2'd0, 4, 5, 1'b0, 1'b0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) send(12'h3C5 ^ 12'(m * 291), 2'(m), 4, 5, 1'b0, 1'b0);
  endtask

  task automatic t_extremes();
    send(12'h000, 2'd3, 4, 5, 1'b0, 1'b0);
    send(12'hFFF, 2'd1, 4, 5, 1'b0, 1'b0);
  endtask

  task automatic t_fast();
    send(12'h5A5, 2'd2, 1, 1, 1'b0, 1'b0);
    send(12'h801, 2'd1, 0, 0, 1'b0, 1'b0);
    send(12'h7FE, 2'd0, 3, 9, 1'b0, 1'b0);
  endtask

  task automatic t_cfg_change();
    // R8: ports switched to 1/1 after acceptance; frame keeps 6/7
    send(12'h9D2, 2'd2, 6, 7, 1'b1, 1'b0);
  endtask

  task automatic t_busy_request();
    int stray;
    // R9: valid pulse inside the busy window must not start a frame
    send(12'h1E7, 2'd0, 2, 3, 1'b0, 1'b1);
    stray = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sel_n || sclk || sdo || !req_ready) stray++;
    end
    check(stray == 0, "R9 ignored busy request", stray, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_modes();
    t_extremes();
    t_fast();
    t_cfg_change();
    t_busy_request();
    finish_run();
  end
endmodule